// File: doc/BRIEF.md
# Reverse-Channel Byte Receiver with Run-Length Expansion

This block drives the host side of a reverse-direction byte transfer in a parallel-port link that runs an enhanced bidirectional protocol. While its enable is high (full enhanced mode with the direction set to reverse) and the downstream FIFO has room, it lowers its request line. It then waits for the peripheral's acknowledge and its release, captures the byte on the data pins, and sorts that byte as data or command using the peripheral's BUSY level.

Data bytes go to a FIFO push port. A command byte with its top bit set is dropped. A command byte with its top bit clear is taken as a run length. The next byte read is then always treated as data and is pushed count+1 times. Before each of these pushes the block checks the FIFO full flag. If the enable drops, any count waiting for its byte and any expansion in progress are cancelled.

Top module: `ecp_rev_rle`

## Requirements
- R1: After reset `req_no` is 1 and `push_o` is 0. A new request (`req_no` low) starts only while `en_i` is 1 and `fifo_full_i` is 0.
- R2: A request stays low until `ack_i` (1 = asserted) is seen. `req_no` then returns to 1 within four clock cycles. The byte on `data_i` is captured when the release of `ack_i` is detected.
- R3: A byte read with `busy_i` = 1 is a data byte. It is pushed exactly once, and `push_data_o` equals the captured `data_i`.
- R4: A byte read with `busy_i` = 0 and bit 7 = 1 is a command that is dropped. It causes no push.
- R5: A byte read with `busy_i` = 0 and bit 7 = 0 loads its bits 6:0 as a repeat count N and causes no push. The next byte read is data whatever the level of `busy_i`, and it is pushed N+1 times (from 1 up to 128 pushes).
- R6: No push occurs in a cycle where `fifo_full_i` is 1. An expansion stalls while the FIFO is full and then resumes with its remaining count unchanged.
- R7: `en_i` low returns the handshake to idle with `req_no` = 1, and it clears any pending count and any expansion in progress. Once re-enabled, the block pushes nothing until a new byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Reverse enhanced-mode enable; low aborts |
| busy_i | input | 1 | Peripheral class line: 1 = data, 0 = command |
| ack_i | input | 1 | Peripheral acknowledge, 1 = asserted |
| data_i | input | 8 | Peripheral data pins |
| fifo_full_i | input | 1 | FIFO full flag |
| req_no | output | 1 | Host request line, low = request a byte |
| push_o | output | 1 | FIFO push strobe |
| push_data_o | output | 8 | Byte to push |

## Verification
The bench sweeps every data value, every command value with the top bit set, and every repeat count from 0 to 127. A count that is off by one would show up as one push too many or too few at the smallest and largest runs. A design that followed BUSY on the byte after a count would drop that byte, because the bench drives BUSY low for it. The bench holds the FIFO full during an expansion: a design that skipped the full check would push during the stall, and one that lost its count would push too few bytes after the stall ends. It also drops the enable with a count pending and again in the middle of a stalled expansion. A design that did not clear its state would push stale bytes after re-enable.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RUN_W  = BYTE_W - 1;

  typedef enum logic [1:0] {
    LK_IDLE,
    LK_REQ,
    LK_HOLD
  } link_st_e;
endpackage

// File: rtl/ecp_rev_sync.sv
module ecp_rev_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ecp_rev_link.sv
module ecp_rev_link
  import ecp_rev_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fifo_full_i,
  input  logic              sink_rdy_i,
  input  logic              ack_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              req_no,
  output logic              rx_vld_o,
  output logic              rx_cmd_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  link_st_e st_q;
  logic     ack_s, busy_s;

  ecp_rev_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ack_i, busy_i}),
    .q_o   ({ack_s, busy_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= LK_IDLE;
    end else if (!en_i) begin
      st_q <= LK_IDLE;
    end else begin
      unique case (st_q)
        LK_IDLE: if (!fifo_full_i && sink_rdy_i) st_q <= LK_REQ;
        LK_REQ:  if (ack_s) st_q <= LK_HOLD;
        LK_HOLD: if (!ack_s) st_q <= LK_IDLE;
        default: st_q <= LK_IDLE;
      endcase
    end
  end

  // byte captured on the edge that sees the acknowledge released
  assign rx_vld_o  = en_i && (st_q == LK_HOLD) && !ack_s;
  assign rx_cmd_o  = !busy_s;
  assign rx_byte_o = data_i;
  assign req_no    = (st_q != LK_REQ);

  a_r1_no_req_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LK_IDLE && fifo_full_i) |=> (st_q != LK_REQ));

  a_r2_ack_lifts_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LK_REQ && ack_s && en_i) |=> req_no);
endmodule

// File: rtl/ecp_rev_expand.sv
module ecp_rev_expand
  import ecp_rev_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fifo_full_i,
  input  logic              rx_vld_i,
  input  logic              rx_cmd_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              sink_rdy_o,
  output logic              push_o,
  output logic [BYTE_W-1:0] push_data_o
);
  logic [RUN_W-1:0]  run_cnt_q;
  logic              run_pend_q;
  logic              run_act_q;
  logic [BYTE_W-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt_q  <= '0;
      run_pend_q <= 1'b0;
      run_act_q  <= 1'b0;
      byte_q     <= '0;
    end else if (!en_i) begin
      run_cnt_q  <= '0;
      run_pend_q <= 1'b0;
      run_act_q  <= 1'b0;
    end else if (run_act_q) begin
      if (!fifo_full_i) begin
        if (run_cnt_q == '0) run_act_q <= 1'b0;
        else                 run_cnt_q <= run_cnt_q - 1'b1;
      end
    end else if (rx_vld_i) begin
      if (run_pend_q || !rx_cmd_i) begin
        // data byte, or the byte that follows a run count
        run_act_q  <= 1'b1;
        byte_q     <= rx_byte_i;
        run_pend_q <= 1'b0;
      end else if (!rx_byte_i[BYTE_W-1]) begin
        run_cnt_q  <= rx_byte_i[RUN_W-1:0];
        run_pend_q <= 1'b1;
      end
    end
  end

  assign sink_rdy_o  = !run_act_q;
  assign push_o      = en_i && run_act_q && !fifo_full_i;
  assign push_data_o = byte_q;

  a_r3_single_delivery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld_i |-> !run_act_q);

  a_r6_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_act_q && fifo_full_i && en_i) |=> (run_act_q && $stable(run_cnt_q)));

  a_r7_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!run_act_q && !run_pend_q && run_cnt_q == '0));
endmodule

// File: rtl/ecp_rev_rle.sv
module ecp_rev_rle
  import ecp_rev_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              busy_i,
  input  logic              ack_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              fifo_full_i,
  output logic              req_no,
  output logic              push_o,
  output logic [BYTE_W-1:0] push_data_o
);
  logic              sink_rdy, rx_vld, rx_cmd;
  logic [BYTE_W-1:0] rx_byte;

  ecp_rev_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .fifo_full_i(fifo_full_i),
    .sink_rdy_i (sink_rdy),
    .ack_i      (ack_i),
    .busy_i     (busy_i),
    .data_i     (data_i),
    .req_no     (req_no),
    .rx_vld_o   (rx_vld),
    .rx_cmd_o   (rx_cmd),
    .rx_byte_o  (rx_byte)
  );

  ecp_rev_expand u_expand (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .fifo_full_i(fifo_full_i),
    .rx_vld_i   (rx_vld),
    .rx_cmd_i   (rx_cmd),
    .rx_byte_i  (rx_byte),
    .sink_rdy_o (sink_rdy),
    .push_o     (push_o),
    .push_data_o(push_data_o)
  );
endmodule

// File: tb/ecp_rev_rle_test.sv
module ecp_rev_rle_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, busy, ack, full;
  logic [7:0] data;
  logic       req_no, push;
  logic [7:0] push_data;

  int checks = 0;
  int fails  = 0;
  int pushes = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ecp_rev_rle uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .busy_i(busy), .ack_i(ack),
    .data_i(data), .fifo_full_i(full), .req_no(req_no), .push_o(push),
    .push_data_o(push_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // push monitor: compares against bench-computed queue
  always @(negedge clk) begin
    if (rst_n && push) begin
      pushes++;
      chk(!full, "R6 push while full", 1, 0);
      if (exp_q.size() == 0) chk(1'b0, "R4/R7 unexpected push", int'(push_data), -1);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        chk(push_data == e, "R3 push data", int'(push_data), int'(e));
      end
    end
  end

  task automatic send(input bit cmd, input logic [7:0] b, input bit raise_full);
    int n;
    while (req_no) @(negedge clk);
    data = b; busy = !cmd; ack = 1'b1;
    if (raise_full) full = 1'b1;
    n = 0;
    while (!req_no) begin @(negedge clk); n++; end
    chk(n <= 4, "R2 request release latency", n, 4);
    ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
    $finish;
  end

  initial begin
    int p0;
    bit seen_low;
    rst_n = 0; en = 0; busy = 1; ack = 0; full = 0; data = 8'h00;
    repeat (5) @(negedge clk);
    chk(req_no == 1'b1, "R1 reset req", req_no, 1);
    chk(push == 1'b0, "R1 reset push", push, 0);
    rst_n = 1;
    @(negedge clk);
    en = 1;

    // R3: every data value, BUSY high
    for (int b = 0; b < 256; b++) begin
      exp_q.push_back(8'(b));
      send(1'b0, 8'(b), 1'b0);
    end
    drain("R3 data sweep");

    // R4: all commands with bit 7 set are dropped
    p0 = pushes;
    for (int b = 128; b < 256; b++) send(1'b1, 8'(b), 1'b0);
    exp_q.push_back(8'hA5);
    send(1'b0, 8'hA5, 1'b0);
    drain("R4 after discard");
    chk(pushes - p0 == 1, "R4 discard push count", pushes - p0, 1);

    // R5: every run count, data byte sent with BUSY low
    for (int c = 0; c < 128; c++) begin
      automatic logic [7:0] d = 8'(c) ^ 8'h5A;
      p0 = pushes;
      send(1'b1, 8'(c), 1'b0);
      for (int k = 0; k <= c; k++) exp_q.push_back(d);
      send(1'b1, d, 1'b0);
      drain("R5 expansion drained");
      chk(pushes - p0 == c + 1, "R5 expansion count", pushes - p0, c + 1);
    end

    // R5: run count followed by a BUSY-high byte
    p0 = pushes;
    send(1'b1, 8'd2, 1'b0);
    repeat (3) exp_q.push_back(8'hE7);
    send(1'b0, 8'hE7, 1'b0);
    drain("R5 busy-high data");
    chk(pushes - p0 == 3, "R5 busy-high count", pushes - p0, 3);

    // R1: no request while full
    en = 0;
    repeat (2) @(negedge clk);
    full = 1; en = 1;
    seen_low = 0;
    repeat (20) begin @(negedge clk); if (!req_no) seen_low = 1; end
    chk(!seen_low, "R1 request while full", seen_low, 0);
    full = 0;
    repeat (5) @(negedge clk);
    chk(req_no == 1'b0, "R1 request after room", req_no, 0);

    // R6: stall mid-expansion
    p0 = pushes;
    send(1'b1, 8'd3, 1'b0);
    send(1'b0, 8'hC3, 1'b1);
    repeat (15) @(negedge clk);
    chk(pushes - p0 == 0, "R6 stalled pushes", pushes - p0, 0);
    repeat (4) exp_q.push_back(8'hC3);
    full = 0;
    drain("R6 resumed");
    chk(pushes - p0 == 4, "R6 total after stall", pushes - p0, 4);

    // R7: abort with a count pending
    p0 = pushes;
    send(1'b1, 8'd5, 1'b0);
    en = 0;
    repeat (3) @(negedge clk);
    chk(req_no == 1'b1, "R7 idle on abort", req_no, 1);
    en = 1;
    exp_q.push_back(8'h3C);
    send(1'b0, 8'h3C, 1'b0);
    drain("R7 count cleared");
    chk(pushes - p0 == 1, "R7 single push after abort", pushes - p0, 1);

    // R7: abort during stalled expansion
    p0 = pushes;
    send(1'b1, 8'd9, 1'b0);
    send(1'b0, 8'h77, 1'b1);
    repeat (5) @(negedge clk);
    en = 0;
    repeat (3) @(negedge clk);
    full = 0;
    repeat (3) @(negedge clk);
    en = 1;
    repeat (20) @(negedge clk);
    chk(pushes - p0 == 0, "R7 expansion cancelled", pushes - p0, 0);
    exp_q.push_back(8'h11);
    send(1'b0, 8'h11, 1'b0);
    drain("R7 clean restart");
    chk(pushes - p0 == 1, "R7 restart count", pushes - p0, 1);

    report();
    $finish;
  end
endmodule